// File: doc/BRIEF.md
# Serial channel mode and clock front end

This block is the per-channel configuration and clocking front end of a multi-mode serial unit. It keeps a 16-bit mode word that software writes over a simple register bus. From that word it picks which of two prescaled clock enables becomes the channel's operation clock. It then builds the transfer clock, either by dividing the operation clock by a ratio from the data register's upper seven bits or by detecting edges on the external serial clock pin when the channel is a clocked-serial slave. It also produces the transfer-start event and passes received data on, inverting it when asked to in UART mode.

While the channel is enabled the mode word is locked, except for its lowest bit. The start event comes either from the software start bit alone, or from a falling edge on the receive line once that bit has armed the channel. The 3-bit mode field goes out to the shift engine, which decodes it.

Top module: `sercfg_chan`

## Requirements
- R1: After reset the mode word reads 0x0020, and start_pulse and xfer_clk_en are low.
- R2: Bits 13 to 9, 7, 4 and 3 of rd_data always read 0, and bit 5 always reads 1, whatever value is written.
- R3: With chan_en low, a write stores bits 15, 14, 8, 6 and 2 to 0 of wr_data, and they are visible on rd_data in the next cycle.
- R4: With chan_en high, a write changes only bit 0 of the mode word and leaves every other bit unchanged.
- R5: op_clk_en follows pclk_en1 when bit 15 is 1, and follows pclk_en0 when bit 15 is 0.
- R6: With bit 14 at 0 and chan_en high, xfer_clk_en is a one-cycle pulse every 2×(N+1) operation-clock ticks, where N is div_val.
- R7: With bit 14 at 1, xfer_clk_en pulses once for each rising and each falling edge of sck_in, after a two-flop synchronizer.
- R8: With bit 8 at 0, start_pulse goes high for one cycle, in the cycle after start_set.
- R9: With bit 8 at 1, a falling edge of rxd_in that arrives after start_set produces exactly one start_pulse, and the channel then disarms. Edges that arrive before arming, or after the pulse, are ignored.
- R10: If start_set arrives in the same cycle that an armed falling edge is detected, the pulse is produced and the channel stays armed for the next edge.
- R11: rx_data is the synchronized rxd_in, inverted only when bit 6 is 1 and mode bits 2:1 equal 01 (UART).
- R12: mode_sel always equals bits 2:0 of the mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode-word write strobe |
| wr_data | input | 16 | Mode-word write data |
| rd_data | output | 16 | Mode-word readback |
| chan_en | input | 1 | Channel running flag; locks the mode word |
| start_set | input | 1 | Channel start bit set pulse |
| pclk_en0 | input | 1 | Prescaled clock enable 0 |
| pclk_en1 | input | 1 | Prescaled clock enable 1 |
| div_val | input | 7 | Divider value from the data register's upper bits |
| sck_in | input | 1 | External serial clock pin |
| rxd_in | input | 1 | Receive data pin |
| op_clk_en | output | 1 | Selected operation-clock enable |
| xfer_clk_en | output | 1 | Transfer-clock enable pulse |
| start_pulse | output | 1 | Transfer-start event |
| rx_data | output | 1 | Synchronized, optionally inverted, receive data |
| mode_sel | output | 3 | Mode field for the shift engine |

## Verification
The armed receive-edge detector and the software start bit can act in the same cycle: one clears the arming and the other sets it. The bench arms the channel, drops rxd_in, and raises start_set in exactly the cycle the synchronized edge is seen. It then requires one start pulse in that window and a second pulse on the next falling edge, which shows that the arming survived. Locked writes, which carry new values for every bit at once, are judged by whether bit 0 alone moves on rd_data.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int MW = 16;
  localparam logic [MW-1:0] KEEP_MASK = 16'hC147;
  localparam logic [MW-1:0] FIXED_ONE = 16'h0020;
  localparam logic [1:0]    KIND_UART = 2'b01;

  typedef struct packed {
    logic       clk_sel;
    logic       ext_clk;
    logic       edge_start;
    logic       rx_inv;
    logic [2:0] mode;
  } mode_fields_t;

  function automatic mode_fields_t unpack_word(input logic [MW-1:0] w);
    mode_fields_t f;
    f.clk_sel    = w[15];
    f.ext_clk    = w[14];
    f.edge_start = w[8];
    f.rx_inv     = w[6];
    f.mode       = w[2:0];
    return f;
  endfunction

  function automatic logic [MW-1:0] pack_word(input mode_fields_t f);
    logic [MW-1:0] w;
    w       = FIXED_ONE;
    w[15]   = f.clk_sel;
    w[14]   = f.ext_clk;
    w[8]    = f.edge_start;
    w[6]    = f.rx_inv;
    w[2:0]  = f.mode;
    return w;
  endfunction
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RST_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sercfg_modereg.sv
module sercfg_modereg
  import sercfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [MW-1:0] wr_data,
  input  logic          chan_en,
  output mode_fields_t  fields,
  output logic [MW-1:0] rd_data
);
  mode_fields_t fld_q, fld_d, wr_f;

  always_comb begin
    wr_f  = unpack_word(wr_data);
    fld_d = fld_q;
    if (wr_en) begin
      if (chan_en) fld_d.mode[0] = wr_f.mode[0];
      else         fld_d = wr_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_q <= unpack_word(FIXED_ONE);
    else        fld_q <= fld_d;
  end

  assign fields  = fld_q;
  assign rd_data = pack_word(fld_q);
endmodule

// File: rtl/sercfg_clkgen.sv
module sercfg_clkgen #(
  parameter int DIV_W  = 7,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             clk_sel,
  input  logic             ext_clk,
  input  logic             pclk_en0,
  input  logic             pclk_en1,
  input  logic [DIV_W-1:0] div_val,
  input  logic             sck_in,
  output logic             op_clk_en,
  output logic             xfer_clk_en
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_cnt;
  logic             div_hit;
  logic             div_pls_q, div_pls_d;
  logic             sck_s, sck_hist_q, sck_pls_q, sck_pls_d;

  assign op_clk_en = clk_sel ? pclk_en1 : pclk_en0;
  assign last_cnt  = {div_val, 1'b1};
  assign div_hit   = (cnt_q >= last_cnt);

  always_comb begin
    cnt_d     = cnt_q;
    div_pls_d = 1'b0;
    if (!chan_en || ext_clk) begin
      cnt_d = '0;
    end else if (op_clk_en) begin
      if (div_hit) begin
        cnt_d     = '0;
        div_pls_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  sercfg_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sck_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sck_in),
    .dout  (sck_s)
  );

  assign sck_pls_d = ext_clk & (sck_s ^ sck_hist_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      div_pls_q  <= 1'b0;
      sck_hist_q <= 1'b0;
      sck_pls_q  <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      div_pls_q  <= div_pls_d;
      sck_hist_q <= sck_s;
      sck_pls_q  <= sck_pls_d;
    end
  end

  assign xfer_clk_en = ext_clk ? sck_pls_q : div_pls_q;
endmodule

// File: rtl/sercfg_startgen.sv
module sercfg_startgen #(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_clk_en,
  input  logic       edge_start,
  input  logic       rx_inv,
  input  logic [2:0] mode,
  input  logic       start_set,
  input  logic       rxd_in,
  output logic       start_pulse,
  output logic       rx_data
);
  import sercfg_pkg::*;

  logic rxd_s, rxd_prev_q, rxd_prev_d;
  logic armed_q, armed_d;
  logic pls_q, pls_d;
  logic fall_seen;

  sercfg_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_rxd_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rxd_in),
    .dout  (rxd_s)
  );

  assign fall_seen = op_clk_en & rxd_prev_q & ~rxd_s;

  always_comb begin
    rxd_prev_d = op_clk_en ? rxd_s : rxd_prev_q;
    armed_d    = armed_q;
    pls_d      = 1'b0;
    if (!edge_start) begin
      armed_d = 1'b0;
      pls_d   = start_set;
    end else begin
      if (armed_q && fall_seen) begin
        pls_d   = 1'b1;
        armed_d = 1'b0;
      end
      if (start_set) armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_prev_q <= 1'b1;
      armed_q    <= 1'b0;
      pls_q      <= 1'b0;
    end else begin
      rxd_prev_q <= rxd_prev_d;
      armed_q    <= armed_d;
      pls_q      <= pls_d;
    end
  end

  assign start_pulse = pls_q;
  assign rx_data     = rxd_s ^ (rx_inv & (mode[2:1] == KIND_UART));
endmodule

// File: rtl/sercfg_chan.sv
module sercfg_chan
  import sercfg_pkg::*;
#(
  parameter int DIV_W  = 7,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  output logic [15:0]      rd_data,
  input  logic             chan_en,
  input  logic             start_set,
  input  logic             pclk_en0,
  input  logic             pclk_en1,
  input  logic [DIV_W-1:0] div_val,
  input  logic             sck_in,
  input  logic             rxd_in,
  output logic             op_clk_en,
  output logic             xfer_clk_en,
  output logic             start_pulse,
  output logic             rx_data,
  output logic [2:0]       mode_sel
);
  mode_fields_t fields;

  sercfg_modereg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .chan_en (chan_en),
    .fields  (fields),
    .rd_data (rd_data)
  );

  sercfg_clkgen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_clk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_en     (chan_en),
    .clk_sel     (fields.clk_sel),
    .ext_clk     (fields.ext_clk),
    .pclk_en0    (pclk_en0),
    .pclk_en1    (pclk_en1),
    .div_val     (div_val),
    .sck_in      (sck_in),
    .op_clk_en   (op_clk_en),
    .xfer_clk_en (xfer_clk_en)
  );

  sercfg_startgen #(.SYNC_N(SYNC_N)) u_start (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_clk_en   (op_clk_en),
    .edge_start  (fields.edge_start),
    .rx_inv      (fields.rx_inv),
    .mode        (fields.mode),
    .start_set   (start_set),
    .rxd_in      (rxd_in),
    .start_pulse (start_pulse),
    .rx_data     (rx_data)
  );

  assign mode_sel = fields.mode;
endmodule

// File: rtl/sercfg_chan_chk.sv
module sercfg_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        chan_en,
  input logic        start_set,
  input logic [15:0] rd_data,
  input logic        start_pulse,
  input logic [2:0]  mode_sel
);
  assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[13:9] == 5'd0) && !rd_data[7] && !rd_data[4] && !rd_data[3] && rd_data[5]);

  assert_open_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !chan_en) |=> (rd_data[15:14] == $past(wr_data[15:14])) &&
                            (rd_data[8] == $past(wr_data[8])) &&
                            (rd_data[6] == $past(wr_data[6])));

  assert_locked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && chan_en) |=> (rd_data[15:1] == $past(rd_data[15:1])) &&
                           (rd_data[0] == $past(wr_data[0])));

  assert_sw_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_set && !rd_data[8] && !wr_en) |=> start_pulse);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && rd_data[8] && !$past(start_set) && !start_set) |=> !start_pulse);

  assert_mode_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == rd_data[2:0]);
endmodule

bind sercfg_chan sercfg_chan_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .chan_en     (chan_en),
  .start_set   (start_set),
  .rd_data     (rd_data),
  .start_pulse (start_pulse),
  .mode_sel    (mode_sel)
);

// File: tb/sercfg_chan_tb.sv
module sercfg_chan_tb_top;
  logic        clk, rst_n;
  logic        wr_en, chan_en, start_set, pclk_en0, pclk_en1, sck_in, rxd_in;
  logic [15:0] wr_data, rd_data;
  logic [6:0]  div_val;
  logic        op_clk_en, xfer_clk_en, start_pulse, rx_data;
  logic [2:0]  mode_sel;
  int          n_run, n_fail;
  logic [15:0] mdl;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  sercfg_chan dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .chan_en(chan_en), .start_set(start_set), .pclk_en0(pclk_en0), .pclk_en1(pclk_en1),
    .div_val(div_val), .sck_in(sck_in), .rxd_in(rxd_in), .op_clk_en(op_clk_en),
    .xfer_clk_en(xfer_clk_en), .start_pulse(start_pulse), .rx_data(rx_data),
    .mode_sel(mode_sel)
  );

  function automatic logic [15:0] clean(input logic [15:0] w);
    return (w & 16'hC147) | 16'h0020;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put_word(input logic [15:0] w);
    wr_en = 1'b1; wr_data = w;
    tick();
    wr_en = 1'b0;
    if (chan_en) mdl = {mdl[15:1], w[0]};
    else         mdl = clean(w);
  endtask

  task automatic count_start(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin tick(); c += int'(start_pulse); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c, t0, t1, n;
    logic [15:0] w;
    n_run = 0; n_fail = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 0; wr_data = 0; chan_en = 0; start_set = 0;
    pclk_en0 = 1; pclk_en1 = 0; div_val = 0; sck_in = 0; rxd_in = 1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    mdl = 16'h0020;
    chk("R1 reset word", rd_data, 16'h0020);
    chk("R1 reset start", start_pulse, 0);
    chk("R1 reset xfer", xfer_clk_en, 0);

    for (int i = 0; i < 20; i++) begin
      w = 16'($urandom);
      put_word(w);
      chk("R3 open write", rd_data, mdl);
      chk("R2 reserved bits", rd_data & 16'h3EB8, 16'h0020);
      chk("R12 mode out", mode_sel, mdl[2:0]);
    end
    put_word(16'hFFFF);
    chk("R2 all ones", rd_data, 16'hC167);

    chan_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      w = 16'($urandom);
      put_word(w);
      chk("R4 locked write", rd_data, mdl);
      chk("R12 mode out locked", mode_sel, mdl[2:0]);
    end
    chan_en = 1'b0;

    put_word(16'h8000);
    for (int i = 0; i < 8; i++) begin
      pclk_en0 = 1'($urandom); pclk_en1 = 1'($urandom); #1;
      chk("R5 clock sel 1", op_clk_en, pclk_en1);
      tick();
    end
    put_word(16'h0000);
    for (int i = 0; i < 8; i++) begin
      pclk_en0 = 1'($urandom); pclk_en1 = 1'($urandom); #1;
      chk("R5 clock sel 0", op_clk_en, pclk_en0);
      tick();
    end
    pclk_en0 = 1; pclk_en1 = 0;

    for (int k = 0; k < 4; k++) begin
      n = (k == 0) ? 0 : (k == 1) ? 5 : (k == 2) ? 127 : int'($urandom_range(1, 60));
      chan_en = 0; div_val = 7'(n); tick();
      chan_en = 1;
      t0 = -1; t1 = -1;
      for (int cyc = 0; cyc < 700 && t1 < 0; cyc++) begin
        tick();
        if (xfer_clk_en) begin
          if (t0 < 0) t0 = cyc; else t1 = cyc;
        end
      end
      chk("R6 divider period", t1 - t0, 2 * (n + 1));
    end
    chan_en = 0; tick();

    put_word(16'h4000);
    chan_en = 1; sck_in = 0;
    repeat (4) tick();
    c = 0;
    for (int e = 0; e < 6; e++) begin
      sck_in = ~sck_in;
      for (int j = 0; j < 4; j++) begin tick(); c += int'(xfer_clk_en); end
    end
    for (int j = 0; j < 4; j++) begin tick(); c += int'(xfer_clk_en); end
    chk("R7 sck edges", c, 6);
    chan_en = 0; sck_in = 0; tick();

    put_word(16'h0000);
    start_set = 1; tick();
    chk("R8 sw start pulse", start_pulse, 1);
    start_set = 0; tick();
    chk("R8 sw start single", start_pulse, 0);

    put_word(16'h0102);
    chan_en = 1;
    rxd_in = 0; count_start(6, c);
    chk("R9 edge before arm", c, 0);
    rxd_in = 1; repeat (4) tick();
    start_set = 1; tick(); start_set = 0;
    rxd_in = 0; count_start(6, c);
    chk("R9 armed edge", c, 1);
    rxd_in = 1; repeat (4) tick();
    rxd_in = 0; count_start(6, c);
    chk("R9 disarmed edge", c, 0);
    rxd_in = 1; repeat (4) tick();

    start_set = 1; tick(); start_set = 0; repeat (2) tick();
    rxd_in = 0; c = 0;
    for (int i = 0; i < 8; i++) begin
      start_set = (i == 2);
      tick();
      c += int'(start_pulse);
    end
    start_set = 0;
    chk("R10 collision pulse", c, 1);
    rxd_in = 1; repeat (4) tick();
    rxd_in = 0; count_start(6, c);
    chk("R10 still armed", c, 1);
    rxd_in = 1; repeat (4) tick();
    chan_en = 0; tick();

    put_word(16'h0042);
    rxd_in = 0; repeat (3) tick();
    chk("R11 uart invert low", rx_data, 1);
    rxd_in = 1; repeat (3) tick();
    chk("R11 uart invert high", rx_data, 0);
    put_word(16'h0040);
    rxd_in = 0; repeat (3) tick();
    chk("R11 no invert outside uart", rx_data, 0);
    put_word(16'h0002);
    repeat (2) tick();
    chk("R11 uart without invert", rx_data, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule